// File: doc/BRIEF.md
# Programmable-Latency Trigger Command Pipeline

This block takes one crossing slot per clock (a valid flag, a trigger-accept bit and a crossing number) and emits the matching fast-control command word after a fixed number of cycles, which software sets. The delay runs through three buffers in turn. First comes a look-back stage that can still edit words already queued. Next is a fixed internal-processing section. Last come two adjustable delay lines: a middle buffer and an output buffer. Together the adjustable lines absorb whatever latency exceeds the minimum.

When a crossing is accepted and the half-window N is non-zero, the block groups that crossing with its N neighbours on each side for consecutive-crossing readout. Every word in the group carries a group flag and a signed position relative to the central crossing. Words that came before the central one are edited in place in the look-back stage. Words that come after are tagged as they arrive. The minimum latency is the largest half-window plus the fixed processing depth. With the default parameters that gives 15 + 7 = 22 cycles, and the maximum is 52.

Top module: `trig_lat_pipe`

## Requirements
- R1: After reset, `cmd_valid` is 0, every command field is 0, `cfg_err` is 0, the half-window is 0 and the latency is the minimum of 22 cycles.
- R2: A crossing sampled with `in_valid`=1 on clock edge t appears on the outputs, with the same `cmd_bxid` and `cmd_yes` = `trig_yes`, during exactly one cycle, starting after edge t+L (L = current latency). A slot with `in_valid`=0 produces `cmd_valid`=0 and all fields 0, whatever `trig_yes` was.
- R3: An accepted configuration write sets L to `cfg_latency` for any value from 22 to 52 inclusive.
- R4: A requested latency below 22 gives L=22, and one above 52 gives L=52. Both set `cfg_err`=1. An accepted in-range write clears `cfg_err`. `cfg_err` changes only on accepted writes.
- R5: A write is accepted only when the pipeline is idle: no valid word in flight, no group window still open, and `in_valid`=0 in that cycle. Any other write has no effect on latency, half-window or `cfg_err`.
- R6: A valid slot with `trig_yes`=1, while no window is open and the half-window N>0, opens a window. Its own word gets `cmd_grp`=1 and `cmd_idx`=0. The next N slots, where valid, get `cmd_grp`=1 and `cmd_idx`=+1..+N in order.
- R7: When a window opens, each valid word among the N preceding slots that is not yet grouped is rewritten to `cmd_grp`=1 with `cmd_idx`=-k (k = distance back, 5-bit two's complement). Words already grouped keep their values, and invalid slots stay all-zero.
- R8: A trigger accept that arrives inside the trailing part of an open window opens no new window. It is carried as a member with `cmd_yes`=1 and that window's position.
- R9: With half-window 0, every word leaves with `cmd_grp`=0 and `cmd_idx`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one crossing slot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Slot holds a crossing |
| trig_yes | input | 1 | Trigger accepted for this crossing |
| in_bxid | input | BX_W | Crossing number |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_half | input | HW_W | Requested half-window |
| cfg_latency | input | LAT_W | Requested total latency in cycles |
| cfg_err | output | 1 | Last accepted latency request was out of range |
| cmd_valid | output | 1 | Command word strobe |
| cmd_yes | output | 1 | Trigger-accept bit of the word |
| cmd_grp | output | 1 | Word belongs to a consecutive-readout group |
| cmd_idx | output | IDX_W | Signed position relative to the group centre |
| cmd_bxid | output | BX_W | Crossing number of the word |

## Verification
The bench targets window edits that reach back into the look-back stage. It covers a gap slot inside the leading part of a window, a second window that opens right after the first one closes, an accept inside an open window, and the maximum half-window of 15. A design that overwrote grouped words, tagged invalid slots or reopened a window mid-group would show a wrong index or flag on the cycle-compared output. It also measures latency at the minimum, at the maximum and clamped from both sides, and checks that a latency change flushes stale words. A design that kept old entries in its delay lines would emit a phantom word after a latency increase. Writes issued while words are in flight, or in the same cycle as a valid slot, must leave the latency, window and error flag unchanged.

// File: rtl/trig_lat_pipe.sv
module trig_lat_pipe #(
  parameter int BX_W    = 12,
  parameter int HW_MAX  = 15,
  parameter int FIX_CYC = 7,
  parameter int MID_MAX = 15,
  parameter int OUT_MAX = 15,
  parameter int LAT_W   = 8,
  parameter int HW_W    = $clog2(HW_MAX + 1),
  parameter int IDX_W   = HW_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             trig_yes,
  input  logic [BX_W-1:0]  in_bxid,
  input  logic             cfg_wr,
  input  logic [HW_W-1:0]  cfg_half,
  input  logic [LAT_W-1:0] cfg_latency,
  output logic             cfg_err,
  output logic             cmd_valid,
  output logic             cmd_yes,
  output logic             cmd_grp,
  output logic [IDX_W-1:0] cmd_idx,
  output logic [BX_W-1:0]  cmd_bxid
);
  localparam int MIN_LAT = HW_MAX + FIX_CYC;
  localparam int MAX_LAT = MIN_LAT + MID_MAX + OUT_MAX;
  localparam int FIX_N   = FIX_CYC - 2;
  localparam int MID_W   = $clog2(MID_MAX + 1);
  localparam int OUT_W   = $clog2(OUT_MAX + 1);
  localparam int OCC_W   = $clog2(MAX_LAT + 2);
  localparam logic [LAT_W-1:0] MIN_L  = LAT_W'(MIN_LAT);
  localparam logic [LAT_W-1:0] MAX_L  = LAT_W'(MAX_LAT);
  localparam logic [LAT_W-1:0] SPAN_L = LAT_W'(MID_MAX + OUT_MAX);
  localparam logic [LAT_W-1:0] MIDM_L = LAT_W'(MID_MAX);

  typedef struct packed {
    logic             v;
    logic             y;
    logic             g;
    logic [IDX_W-1:0] idx;
    logic [BX_W-1:0]  bx;
  } word_t;

  word_t lb     [HW_MAX+1];
  word_t fix_sr [FIX_N];
  word_t mid_sr [MID_MAX+1];
  word_t out_sr [OUT_MAX+1];
  word_t new_w, mid_tap, out_w;

  logic [HW_W-1:0]  half_q, post_cnt, half_n;
  logic [IDX_W-1:0] post_pos;
  logic [MID_W-1:0] mid_d, mid_n;
  logic [OUT_W-1:0] out_d, out_n;
  logic [OCC_W-1:0] occ;
  logic [LAT_W-1:0] ext;
  logic             err_q, lat_lo, lat_hi;

  wire idle     = (occ == '0) && !in_valid && (post_cnt == '0);
  wire cfg_take = cfg_wr && idle;
  wire open_win = in_valid && trig_yes && (post_cnt == '0) && (half_q != '0);

  always_comb begin
    new_w = '0;
    if (in_valid) begin
      new_w.v  = 1'b1;
      new_w.y  = trig_yes;
      new_w.bx = in_bxid;
      if (open_win) new_w.g = 1'b1;
      else if (post_cnt != '0) begin
        new_w.g   = 1'b1;
        new_w.idx = post_pos;
      end
    end
  end

  always_comb begin
    lat_lo = cfg_latency < MIN_L;
    lat_hi = cfg_latency > MAX_L;
    ext    = lat_lo ? '0 : (lat_hi ? SPAN_L : cfg_latency - MIN_L);
    mid_n  = (ext > MIDM_L) ? MID_W'(MID_MAX) : MID_W'(ext);
    out_n  = OUT_W'(ext - LAT_W'(mid_n));
    half_n = (cfg_half > HW_W'(HW_MAX)) ? HW_W'(HW_MAX) : cfg_half;
  end

  // look-back stage: the newest HW_MAX words may still be rewritten
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i <= HW_MAX; i++) lb[i] <= '0;
    end else begin
      lb[0] <= new_w;
      for (int i = 0; i < HW_MAX; i++) begin
        lb[i+1] <= lb[i];
        if (open_win && HW_W'(i) < half_q && lb[i].v && !lb[i].g) begin
          lb[i+1].g   <= 1'b1;
          lb[i+1].idx <= IDX_W'(-(i + 1));
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int j = 0; j < FIX_N; j++) fix_sr[j] <= '0;
    end else begin
      fix_sr[0] <= lb[HW_MAX];
      for (int j = 1; j < FIX_N; j++) fix_sr[j] <= fix_sr[j-1];
    end
  end

  assign mid_tap = mid_sr[mid_d];
  assign out_w   = out_sr[out_d];

  always_ff @(posedge clk) begin
    if (!rst_n || cfg_take) begin
      for (int j = 0; j <= MID_MAX; j++) mid_sr[j] <= '0;
      for (int j = 0; j <= OUT_MAX; j++) out_sr[j] <= '0;
    end else begin
      mid_sr[0] <= fix_sr[FIX_N-1];
      for (int j = 1; j <= MID_MAX; j++) mid_sr[j] <= mid_sr[j-1];
      out_sr[0] <= mid_tap;
      for (int j = 1; j <= OUT_MAX; j++) out_sr[j] <= out_sr[j-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      post_cnt <= '0;
      post_pos <= '0;
    end else if (open_win) begin
      post_cnt <= half_q;
      post_pos <= IDX_W'(1);
    end else if (post_cnt != '0) begin
      post_cnt <= post_cnt - HW_W'(1);
      post_pos <= post_pos + IDX_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      half_q <= '0;
      mid_d  <= '0;
      out_d  <= '0;
      err_q  <= 1'b0;
      occ    <= '0;
    end else begin
      if (cfg_take) begin
        half_q <= half_n;
        mid_d  <= mid_n;
        out_d  <= out_n;
        err_q  <= lat_lo | lat_hi;
      end
      occ <= occ + OCC_W'(in_valid) - OCC_W'(out_w.v);
    end
  end

  assign cfg_err   = err_q;
  assign cmd_valid = out_w.v;
  assign cmd_yes   = out_w.y;
  assign cmd_grp   = out_w.g;
  assign cmd_idx   = out_w.idx;
  assign cmd_bxid  = out_w.bx;
endmodule

// File: rtl/trig_lat_pipe_chk.sv
module trig_lat_pipe_chk #(
  parameter int BX_W  = 12,
  parameter int HW_W  = 4,
  parameter int IDX_W = 5,
  parameter int MID_W = 4,
  parameter int OUT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr,
  input logic             in_valid,
  input logic             cfg_err,
  input logic             cmd_valid,
  input logic             cmd_yes,
  input logic             cmd_grp,
  input logic [IDX_W-1:0] cmd_idx,
  input logic [BX_W-1:0]  cmd_bxid,
  input logic [HW_W-1:0]  half_q,
  input logic [MID_W-1:0] mid_d,
  input logic [OUT_W-1:0] out_d
);
  a_r2_empty_slot_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> (cmd_bxid == '0 && !cmd_yes && !cmd_grp && cmd_idx == '0));

  a_r4_err_moves_on_write_only: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(cfg_err));

  a_r5_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && in_valid) |=> ($stable(mid_d) && $stable(out_d) && $stable(half_q) && $stable(cfg_err)));

  a_r6_centre_is_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_grp && cmd_idx == '0) |-> cmd_yes);

  a_r7_idx_within_half: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_grp |-> ($signed(cmd_idx) <= $signed({1'b0, half_q}) &&
                 $signed(cmd_idx) >= -$signed({1'b0, half_q})));

  a_r9_no_group_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (half_q == '0) |-> !cmd_grp);
endmodule

bind trig_lat_pipe trig_lat_pipe_chk #(
  .BX_W(BX_W), .HW_W(HW_W), .IDX_W(IDX_W), .MID_W(MID_W), .OUT_W(OUT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .in_valid(in_valid),
  .cfg_err(cfg_err), .cmd_valid(cmd_valid), .cmd_yes(cmd_yes),
  .cmd_grp(cmd_grp), .cmd_idx(cmd_idx), .cmd_bxid(cmd_bxid),
  .half_q(half_q), .mid_d(mid_d), .out_d(out_d)
);

// File: tb/trig_lat_pipe_bench.sv
module trig_lat_pipe_bench;
  localparam int LMIN = 22;
  localparam int LMAX = 52;
  localparam int NS   = 8192;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, trig_yes = 1'b0, cfg_wr = 1'b0;
  logic [11:0] in_bxid = '0;
  logic [3:0]  cfg_half = '0;
  logic [7:0]  cfg_latency = '0;
  logic cfg_err, cmd_valid, cmd_yes, cmd_grp;
  logic [4:0]  cmd_idx;
  logic [11:0] cmd_bxid;

  always #4 clk = ~clk;

  trig_lat_pipe u_trig_lat_pipe (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .trig_yes(trig_yes),
    .in_bxid(in_bxid), .cfg_wr(cfg_wr), .cfg_half(cfg_half),
    .cfg_latency(cfg_latency), .cfg_err(cfg_err), .cmd_valid(cmd_valid),
    .cmd_yes(cmd_yes), .cmd_grp(cmd_grp), .cmd_idx(cmd_idx), .cmd_bxid(cmd_bxid)
  );

  int vectors = 0, miscompares = 0, cyc = 0;
  string ph = "R1";

  // reference model state
  bit mv [NS]; bit my [NS]; bit mg [NS]; int mi [NS]; int mb [NS];
  int c = 0, lat_m = LMIN, half_m = 0, post_rem = 0, post_pos = 0;
  int lv = -1000, cfg_edge = -1;
  bit err_m = 0;

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rst_n && c < NS) begin
      bit idle_m;
      idle_m = (lv + lat_m + 2 <= c) && !in_valid && post_rem == 0;
      if (cfg_wr && idle_m) begin
        int rl;
        rl = int'(cfg_latency);
        if (rl < LMIN) begin lat_m = LMIN; err_m = 1; end
        else if (rl > LMAX) begin lat_m = LMAX; err_m = 1; end
        else begin lat_m = rl; err_m = 0; end
        half_m = int'(cfg_half);
        cfg_edge = c;
      end
      mv[c] = in_valid; my[c] = in_valid && trig_yes;
      mb[c] = in_valid ? int'(in_bxid) : 0; mg[c] = 0; mi[c] = 0;
      if (in_valid) lv = c;
      if (in_valid && trig_yes && post_rem == 0 && half_m > 0) begin
        for (int k = 1; k <= half_m; k++)
          if (c - k >= 0 && mv[c-k] && !mg[c-k]) begin mg[c-k] = 1; mi[c-k] = -k; end
        mg[c] = 1; mi[c] = 0; post_rem = half_m; post_pos = 1;
      end else if (post_rem > 0) begin
        if (in_valid) begin mg[c] = 1; mi[c] = post_pos; end
        post_rem--; post_pos++;
      end
      c++;
    end
  end

  always @(negedge clk) begin
    if (rst_n && c > 0) begin
      int src;
      logic [20:0] ew, aw;
      src = (c - 1) - lat_m;
      if (src < 0 || src <= cfg_edge) ew = {err_m, 20'h0};
      else ew = {err_m, mv[src], my[src], mg[src], 5'(mi[src]), 12'(mb[src])};
      aw = {cfg_err, cmd_valid, cmd_yes, cmd_grp, cmd_idx, cmd_bxid};
      chk(ph, int'(aw), int'(ew));
    end
  end

  task automatic step(bit v, bit y, int b);
    @(negedge clk);
    in_valid = v; trig_yes = y; in_bxid = 12'(b); cfg_wr = 1'b0;
  endtask

  task automatic quiet(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0);
  endtask

  task automatic cfg(int lat, int half, bit busy);
    @(negedge clk);
    in_valid = busy; trig_yes = 1'b0; in_bxid = 12'h7ff;
    cfg_wr = 1'b1; cfg_latency = 8'(lat); cfg_half = 4'(half);
    @(negedge clk);
    cfg_wr = 1'b0; in_valid = 1'b0;
  endtask

  task automatic stream(int n, int y1, int y2, int gap, int base);
    for (int i = 0; i < n; i++) step(i != gap, i == y1 || i == y2, base + i);
  endtask

  task automatic meas(int exp_l, string tag, int bx);
    int k;
    k = 0;
    @(negedge clk);
    in_valid = 1'b1; trig_yes = 1'b1; in_bxid = 12'(bx); cfg_wr = 1'b0;
    do begin
      @(negedge clk);
      k++;
      if (k == 1) begin in_valid = 1'b0; trig_yes = 1'b0; end
    end while (!cmd_valid && k < 120);
    chk({tag, " latency"}, k - 1, exp_l);
    chk({tag, " bxid"}, int'(cmd_bxid), bx);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      miscompares++;
      $display("FAIL R2 watchdog actual=%0d expected=<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid", int'(cmd_valid), 0);
    chk("R1 err", int'(cfg_err), 0);
    chk("R1 bxid", int'(cmd_bxid), 0);
    meas(LMIN, "R1", 12'h0a5);
    quiet(5);

    ph = "R2";
    for (int i = 0; i < 60; i++) step(i % 7 != 3, i % 5 == 0, 100 + 3 * i);
    step(0, 1, 12'h3ff);
    quiet(30);

    ph = "R3";
    cfg(30, 0, 0); quiet(2); meas(30, "R3", 12'h111); quiet(35);
    cfg(LMAX, 0, 0); quiet(2); meas(LMAX, "R3", 12'h222);
    stream(20, 4, 9, 6, 400); quiet(60);

    ph = "R4";
    cfg(5, 0, 0); chk("R4 err low", int'(cfg_err), 1);
    meas(LMIN, "R4", 12'h333); quiet(30);
    cfg(200, 0, 0); chk("R4 err high", int'(cfg_err), 1);
    meas(LMAX, "R4", 12'h444); quiet(60);
    cfg(25, 0, 0); chk("R4 err clear", int'(cfg_err), 0);
    meas(25, "R4", 12'h555); quiet(30);

    ph = "R5";
    step(1, 0, 12'h600);
    cfg(40, 4, 0); chk("R5 err kept", int'(cfg_err), 0);
    cfg(3, 4, 0);  chk("R5 err kept", int'(cfg_err), 0);
    quiet(30);
    cfg(3, 4, 1);  chk("R5 err kept same-cycle", int'(cfg_err), 0);
    quiet(30);
    meas(25, "R5", 12'h666);
    stream(12, 5, -1, -1, 700); quiet(30);

    ph = "R6";
    cfg(25, 3, 0); stream(12, 5, -1, -1, 800); quiet(30);
    ph = "R7";
    stream(16, 5, 10, 3, 900); quiet(30);
    ph = "R8";
    stream(14, 4, 6, 8, 1000); quiet(30);
    ph = "R6";
    cfg(25, 15, 0); stream(40, 20, -1, 25, 1100); quiet(40);
    ph = "R7";
    cfg(LMAX, 15, 0); stream(40, 17, 35, 10, 1200); quiet(70);
    ph = "R9";
    cfg(25, 0, 0); stream(20, 3, 11, 7, 1300); quiet(30);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule